// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block performs signed and unsigned 32x32 multiplication and signed and unsigned 32/32 division over many clock cycles, handling one operand bit per cycle. Multiplication adds and shifts, and division subtracts and shifts. The results go into a private pair of 32-bit registers, HI and LO. A multiply writes the 64-bit product across the pair: the upper word goes to HI and the lower word goes to LO. A divide writes the remainder to HI and the quotient to LO. Both registers are always visible on output ports. While the unit is idle, each register can be loaded directly from a shared write-data port.

A caller raises `start` for one cycle with an operation code and two operands. The unit raises `busy` and runs 32 iteration cycles. On the last iteration it updates HI and LO together and drops `busy`. Signed operations are first reduced to magnitudes, which go through the unsigned iteration. The product or quotient is negated at the end when the operand signs differ. The remainder takes the sign of the dividend. A separate three-operand multiply returns only the low word of the signed product on its own output and leaves HI and LO untouched. Division never reports overflow. Dividing by zero takes the same number of cycles as any other divide and gives a fixed result.

Top module: `muldiv_hilo`

## Requirements
- R1: Operation code 1 (unsigned multiply) writes the upper 32 bits of the unsigned 64-bit product to HI and the lower 32 bits to LO.
- R2: Operation code 0 (signed multiply) writes the two's-complement 64-bit product to HI (upper word) and LO (lower word).
- R3: Operation code 3 (unsigned divide) writes the quotient to LO and the remainder to HI.
- R4: Operation code 2 (signed divide) writes a quotient truncated toward zero to LO and a remainder carrying the dividend's sign to HI. The case -2^31 / -1 gives quotient 0x80000000 and remainder 0, with no overflow flag.
- R5: Operation code 4 (three-operand multiply) puts the low 32 bits of the signed product on `mul_low` and leaves HI and LO unchanged.
- R6: A `start` sampled at clock edge E0 raises `busy` at E0. Exactly 32 edges later (E32), `busy` falls, and HI/LO (or `mul_low`) take their new values at that same edge. Before E32, HI and LO do not change.
- R7: A `start` that arrives while `busy` is high is ignored. The running operation finishes unchanged, and no second operation follows it.
- R8: A divide by zero, signed or unsigned, takes the same 32 cycles. It gives LO = 0xFFFFFFFF and HI = the dividend.
- R9: While idle, `wr_hi`/`wr_lo` load `wr_data` into HI/LO at the next edge, and `hi_out`/`lo_out` show the registers at all times. Writes made while `busy` is high are ignored.
- R10: Operation codes 5, 6 and 7 are reserved. A `start` with one of them does not raise `busy` and changes neither HI, LO nor `mul_low`.
- R11: After reset, `busy` is 0 and HI, LO and `mul_low` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (used only when idle) |
| op | input | 3 | Operation code (0 smul, 1 umul, 2 sdiv, 3 udiv, 4 mul-low) |
| opnd_a | input | 32 | Multiplicand or dividend |
| opnd_b | input | 32 | Multiplier or divisor |
| wr_hi | input | 1 | Load HI from wr_data when idle |
| wr_lo | input | 1 | Load LO from wr_data when idle |
| wr_data | input | 32 | Data for direct HI/LO loads |
| busy | output | 1 | Operation in progress |
| hi_out | output | 32 | Current HI register |
| lo_out | output | 32 | Current LO register |
| mul_low | output | 32 | Low word of the last three-operand multiply |

## Verification
- **When results are due:** every arithmetic result is due on the 32nd rising edge after the edge that accepted `start`. A direct HI/LO load is due on the first edge after the write strobe.
- **How the bench samples:** it drives inputs and samples outputs on falling edges. After the start edge it counts 31 falling edges and confirms that `busy` is still high and HI/LO still hold their old values. One falling edge later it confirms that `busy` has dropped and compares the results.
- **Ignored inputs:** a start or a write made during an operation is judged by the registers read back once the running operation has finished.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [2:0] {
        OP_SMUL  = 3'd0,
        OP_UMUL  = 3'd1,
        OP_SDIV  = 3'd2,
        OP_UDIV  = 3'd3,
        OP_MULLO = 3'd4
    } op_e;

    function automatic logic op_is_div(input op_e o);
        return (o == OP_SDIV) || (o == OP_UDIV);
    endfunction

    function automatic logic op_is_signed(input op_e o);
        return (o == OP_SMUL) || (o == OP_SDIV) || (o == OP_MULLO);
    endfunction

endpackage

// File: rtl/muldiv_prep.sv
// Converts operands to magnitudes and records the sign corrections to apply at the end.
module muldiv_prep
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg_lo,
    output logic         neg_hi
);
    logic sa, sb, b_zero;

    always_comb begin
        sa     = op_is_signed(op) & a[W-1];
        sb     = op_is_signed(op) & b[W-1];
        b_zero = (b == '0);
        mag_a  = sa ? (~a + 1'b1) : a;
        mag_b  = sb ? (~b + 1'b1) : b;
        if (op_is_div(op)) begin
            // Quotient is never negated for a zero divisor: it stays all ones.
            neg_lo = (sa ^ sb) & ~b_zero;
            neg_hi = sa;
        end else begin
            neg_lo = sa ^ sb;
            neg_hi = 1'b0;
        end
    end
endmodule

// File: rtl/muldiv_step.sv
// One iteration: shift-and-add for multiply, restoring shift-and-subtract for divide.
module muldiv_step #(
    parameter int W = 32
) (
    input  logic           is_div,
    input  logic [2*W-1:0] acc,
    input  logic [W-1:0]   opb,
    output logic [2*W-1:0] acc_nxt
);
    logic [W:0]   sum;
    logic [W:0]   shifted;
    logic         fits;
    logic [W-1:0] diff;

    always_comb begin
        sum     = {1'b0, acc[2*W-1:W]} + {1'b0, opb};
        shifted = {acc[2*W-1:W], acc[W-1]};
        fits    = shifted >= {1'b0, opb};
        diff    = shifted[W-1:0] - opb;
        if (is_div) begin
            acc_nxt = fits ? {diff, acc[W-2:0], 1'b1}
                           : {shifted[W-1:0], acc[W-2:0], 1'b0};
        end else begin
            acc_nxt = acc[0] ? {sum, acc[W-1:1]}
                             : {1'b0, acc[2*W-1:W], acc[W-1:1]};
        end
    end
endmodule

// File: rtl/muldiv_fix.sv
// Applies sign corrections and maps the final accumulator onto HI/LO.
module muldiv_fix #(
    parameter int W = 32
) (
    input  logic           is_div,
    input  logic [2*W-1:0] acc,
    input  logic           neg_lo,
    input  logic           neg_hi,
    output logic [W-1:0]   hi_res,
    output logic [W-1:0]   lo_res
);
    logic [2*W-1:0] prod;
    logic [W-1:0]   quo, rem;

    always_comb begin
        prod = neg_lo ? (~acc + 1'b1) : acc;
        quo  = neg_lo ? (~acc[W-1:0] + 1'b1) : acc[W-1:0];
        rem  = neg_hi ? (~acc[2*W-1:W] + 1'b1) : acc[2*W-1:W];
        if (is_div) begin
            hi_res = rem;
            lo_res = quo;
        end else begin
            hi_res = prod[2*W-1:W];
            lo_res = prod[W-1:0];
        end
    end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         wr_hi,
    input  logic         wr_lo,
    input  logic [W-1:0] wr_data,
    output logic         busy,
    output logic [W-1:0] hi_out,
    output logic [W-1:0] lo_out,
    output logic [W-1:0] mul_low
);
    localparam int ITERS = W;
    localparam int CNT_W = $clog2(ITERS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ITERS - 1);

    typedef struct packed {
        logic           busy;
        op_e            op;
        logic [CNT_W-1:0] cnt;
        logic [2*W-1:0] acc;
        logic [W-1:0]   opb;
        logic           neg_lo;
        logic           neg_hi;
        logic [W-1:0]   hi;
        logic [W-1:0]   lo;
        logic [W-1:0]   mlow;
    } state_t;

    state_t st_d, st_q;

    op_e            op_in;
    logic           op_ok;
    logic [W-1:0]   mag_a, mag_b;
    logic           pn_lo, pn_hi;
    logic [2*W-1:0] acc_nxt;
    logic [W-1:0]   fix_hi, fix_lo;

    assign op_in = op_e'(op);
    assign op_ok = (op <= 3'd4);

    muldiv_prep #(.W(W)) prep_i (
        .op     (op_in),
        .a      (opnd_a),
        .b      (opnd_b),
        .mag_a  (mag_a),
        .mag_b  (mag_b),
        .neg_lo (pn_lo),
        .neg_hi (pn_hi)
    );

    muldiv_step #(.W(W)) step_i (
        .is_div  (op_is_div(st_q.op)),
        .acc     (st_q.acc),
        .opb     (st_q.opb),
        .acc_nxt (acc_nxt)
    );

    muldiv_fix #(.W(W)) fix_i (
        .is_div (op_is_div(st_q.op)),
        .acc    (acc_nxt),
        .neg_lo (st_q.neg_lo),
        .neg_hi (st_q.neg_hi),
        .hi_res (fix_hi),
        .lo_res (fix_lo)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (wr_hi) st_d.hi = wr_data;
            if (wr_lo) st_d.lo = wr_data;
            if (start && op_ok) begin
                st_d.busy   = 1'b1;
                st_d.op     = op_in;
                st_d.cnt    = '0;
                st_d.acc    = {{W{1'b0}}, mag_a};
                st_d.opb    = mag_b;
                st_d.neg_lo = pn_lo;
                st_d.neg_hi = pn_hi;
            end
        end else begin
            st_d.acc = acc_nxt;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                if (st_q.op == OP_MULLO) begin
                    st_d.mlow = fix_lo;
                end else begin
                    st_d.hi = fix_hi;
                    st_d.lo = fix_lo;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign hi_out  = st_q.hi;
    assign lo_out  = st_q.lo;
    assign mul_low = st_q.mlow;

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> st_q.cnt == '0);

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(st_q.cnt) == LAST);

    // R6
    hilo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(hi_out) && $stable(lo_out));

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && st_q.cnt != LAST |=> busy && $stable(st_q.op) && $stable(st_q.opb));

    // R8
    divzero_quo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && op_is_div($past(st_q.op)) && $past(st_q.opb) == '0 |-> lo_out == '1);

    // R5
    mullo_keeps_hilo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && $past(st_q.op) == OP_MULLO |-> $stable(hi_out) && $stable(lo_out));

    // R10
    reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && op > 3'd4 |=> !busy);
endmodule

// File: tb/muldiv_hilo_tb.sv
`timescale 1ns/1ps
module muldiv_hilo_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] opnd_a = '0, opnd_b = '0, wr_data = '0;
    logic        wr_hi = 1'b0, wr_lo = 1'b0;
    logic        busy;
    logic [31:0] hi_out, lo_out, mul_low;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    muldiv_hilo dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wr_data(wr_data), .busy(busy), .hi_out(hi_out), .lo_out(lo_out),
        .mul_low(mul_low)
    );

    localparam int NV = 16;
    // {op, a, b}
    localparam logic [66:0] VEC [NV] = '{
        {3'd1, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {3'd1, 32'h12345678, 32'h9ABCDEF0},
        {3'd1, 32'h00000000, 32'hDEADBEEF},
        {3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {3'd0, 32'h80000000, 32'h7FFFFFFF},
        {3'd0, 32'hFFFFFFF9, 32'h00000003},
        {3'd0, 32'h80000000, 32'h80000000},
        {3'd3, 32'd100,      32'd7},
        {3'd3, 32'd5,        32'd10},
        {3'd3, 32'hFFFFFFFF, 32'h00000001},
        {3'd2, 32'hFFFFFFF9, 32'd2},
        {3'd2, 32'd7,        32'hFFFFFFFE},
        {3'd2, 32'h80000000, 32'hFFFFFFFF},
        {3'd2, 32'hFFFFFF9C, 32'hFFFFFFF7},
        {3'd4, 32'hFFFFFFFE, 32'd3},
        {3'd4, 32'h0001_0001, 32'h0001_0001}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] eh, output logic [31:0] el);
        logic [63:0]        pu;
        logic signed [63:0] ps, qa, qb;
        case (o)
            3'd1: begin pu = {32'b0, a} * {32'b0, b}; eh = pu[63:32]; el = pu[31:0]; end
            3'd0, 3'd4: begin
                ps = 64'($signed(a)) * 64'($signed(b)); eh = ps[63:32]; el = ps[31:0];
            end
            3'd3: begin
                if (b == 0) begin eh = a; el = '1; end
                else begin eh = a % b; el = a / b; end
            end
            default: begin
                if (b == 0) begin eh = a; el = '1; end
                else begin
                    qa = 64'($signed(a)); qb = 64'($signed(b));
                    ps = qa / qb; el = ps[31:0];
                    ps = qa % qb; eh = ps[31:0];
                end
            end
        endcase
    endfunction

    // Drives start for one edge (E0), then waits 31 edges: busy must still be high.
    task automatic launch(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                          input string req);
        @(negedge clk);
        op = o; opnd_a = a; opnd_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({req, " busy after start"}, 32'(busy), 32'd1);
        repeat (30) @(negedge clk);
    endtask

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'd0: return "R2";
            3'd1: return "R1";
            3'd2: return "R4";
            3'd3: return "R3";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] eh, el, hold_h, hold_l;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy", 32'(busy), 32'd0);
        chk("R11 hi", hi_out, 32'd0);
        chk("R11 lo", lo_out, 32'd0);
        chk("R11 mul_low", mul_low, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            hold_h = hi_out; hold_l = lo_out;
            model(VEC[i][66:64], VEC[i][63:32], VEC[i][31:0], eh, el);
            launch(VEC[i][66:64], VEC[i][63:32], VEC[i][31:0], req_of(VEC[i][66:64]));
            @(negedge clk);
            chk("R6 busy still high at E31", 32'(busy), 32'd1);
            chk("R6 hi held", hi_out, hold_h);
            @(negedge clk);
            chk("R6 busy low at E32", 32'(busy), 32'd0);
            if (VEC[i][66:64] == 3'd4) begin
                chk("R5 mul_low", mul_low, el);
                chk("R5 hi untouched", hi_out, hold_h);
                chk("R5 lo untouched", lo_out, hold_l);
            end else begin
                chk({req_of(VEC[i][66:64]), " hi"}, hi_out, eh);
                chk({req_of(VEC[i][66:64]), " lo"}, lo_out, el);
            end
        end

        // R8 divide by zero, unsigned and signed
        launch(3'd3, 32'h0000_1234, 32'd0, "R8");
        repeat (2) @(negedge clk);
        chk("R8 udiv0 busy", 32'(busy), 32'd0);
        chk("R8 udiv0 lo", lo_out, 32'hFFFFFFFF);
        chk("R8 udiv0 hi", hi_out, 32'h0000_1234);
        launch(3'd2, 32'hFFFF_FF00, 32'd0, "R8");
        repeat (2) @(negedge clk);
        chk("R8 sdiv0 busy", 32'(busy), 32'd0);
        chk("R8 sdiv0 lo", lo_out, 32'hFFFFFFFF);
        chk("R8 sdiv0 hi", hi_out, 32'hFFFF_FF00);

        // R9 direct loads when idle
        @(negedge clk);
        wr_hi = 1'b1; wr_data = 32'hA5A5_0001;
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b1; wr_data = 32'h5A5A_0002;
        chk("R9 hi load", hi_out, 32'hA5A5_0001);
        @(negedge clk);
        wr_lo = 1'b0;
        chk("R9 lo load", lo_out, 32'h5A5A_0002);
        chk("R9 hi kept", hi_out, 32'hA5A5_0001);

        // R9 writes while busy are ignored (mul-low op keeps HI/LO)
        launch(3'd4, 32'd6, 32'd7, "R9");
        wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'hDEAD_0000;
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b0;
        chk("R9 hi not written while busy", hi_out, 32'hA5A5_0001);
        @(negedge clk);
        chk("R9 busy low", 32'(busy), 32'd0);
        chk("R9 hi after op", hi_out, 32'hA5A5_0001);
        chk("R9 lo after op", lo_out, 32'h5A5A_0002);
        chk("R5 mul_low 6*7", mul_low, 32'd42);

        // R7 start while busy ignored
        launch(3'd3, 32'd100, 32'd7, "R7");
        op = 3'd1; opnd_a = 32'd3; opnd_b = 32'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R7 busy low at E32", 32'(busy), 32'd0);
        chk("R7 lo first op", lo_out, 32'd14);
        chk("R7 hi first op", hi_out, 32'd2);
        repeat (3) @(negedge clk);
        chk("R7 no second op", 32'(busy), 32'd0);

        // R10 reserved codes ignored
        for (int c = 5; c < 8; c++) begin
            @(negedge clk);
            op = 3'(c); opnd_a = 32'd9; opnd_b = 32'd9; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R10 no busy", 32'(busy), 32'd0);
            chk("R10 hi unchanged", hi_out, 32'd2);
            chk("R10 lo unchanged", lo_out, 32'd14);
            chk("R10 mul_low unchanged", mul_low, 32'd42);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule